// File: doc/BRIEF.md
# PS/2 Keypad Key-Code Interface

This block sits between a PS/2 keyboard and a reverse-polish calculator engine. It samples the keyboard's clock and data lines, assembles each serial frame into a scan-code byte, and follows the prefix bytes that mark extended keys and key releases. Every recognised keypad press becomes a 5-bit calculator key identifier, aligned to the system clock.

On every system-clock edge the output holds either one key identifier or the idle code `5'h1E`. A press is reported once, in a single cycle, no matter how long the key is held. Scan codes that the calculator does not use never reach the output.

An idle timer watches the keyboard clock. If that clock stays high too long partway through a frame, the timer drops the partial frame so that later frames stay aligned.

Top module: `kp_keycode_rx`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `key_id` is the idle code `5'h1E`. Reset also clears every prefix flag and every held-key flag.
- R2: A frame has 11 bits, each sampled on a falling edge of the synchronised keyboard clock: a start bit 0, eight data bits sent least significant bit first, a parity bit that makes the count of ones in data plus parity odd, and a stop bit 1. A frame with a wrong start bit, wrong stop bit or wrong parity is dropped and produces no key.
- R3: Scan codes 70, 69, 72, 7A, 6B, 73, 74, 6C, 75 and 7D (hex, no extended prefix) give the digits `5'h00` to `5'h09` in that order.
- R4: The operator keys map as follows: 79 to `5'h0C` (add), 7B to `5'h1C` (subtract), 7C to `5'h0D` (multiply), E0 4A to `5'h1D` (divide), 71 to `5'h0E` (decimal point), 77 to `5'h1A` (change sign). Both 5A and E0 5A map to `5'h0A` (enter).
- R5: An E0 prefix applies to the next non-prefix code only. E0 71 gives `5'h0B` (clear entry) and E0 70 gives `5'h1B` (clear all), while 71 and 70 without the prefix keep their meanings from R3 and R4.
- R6: A code that follows an F0 prefix, with or without an E0 before it, produces no key. It releases the held flag of the key it names.
- R7: A key that is held produces no further output on repeated make codes. After its release, the next make code produces the key again.
- R8: Every other scan code produces no key. This includes 4A without the extended prefix. `key_id` only ever takes the values `5'h00`–`5'h0E`, `5'h1A`–`5'h1D` or `5'h1E`.
- R9: A reported key is present for exactly one system-clock cycle. In every other cycle `key_id` is `5'h1E`.
- R10: If the keyboard clock stays high for `IDLE_CYCLES` system clocks, the bit position returns to the start of a frame. A partial frame is then dropped, and the next complete frame decodes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| kb_clk | input | 1 | Keyboard clock line (asynchronous) |
| kb_dat | input | 1 | Keyboard data line (asynchronous) |
| key_id | output | 5 | Key identifier, or `5'h1E` when there is no key |

## Verification
The hardest state to reach from the ports is a frame that stops partway. Only a stalled keyboard clock can create it, and no normal key sequence does. The stimulus sends five bits of a frame, holds the clock high for longer than the idle limit, and then sends a full valid frame that must decode correctly.

Repeated make codes while a key is held, frames that are corrupted in each of their three check fields, and E0 prefixes combined with F0 also need deliberate byte sequences. A behavioural model in the bench predicts the expected key queue for these sequences.

// File: rtl/kp_keycode_rx.sv
module kp_keycode_rx #(
  parameter int IDLE_CYCLES = 50000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       kb_clk,
  input  logic       kb_dat,
  output logic [4:0] key_id
);

  localparam int IW         = $clog2(IDLE_CYCLES + 1);
  localparam int FRAME_BITS = 11;
  localparam logic [3:0] LAST_BIT = 4'(FRAME_BITS - 1);
  localparam logic [4:0] K_NONE   = 5'h1E;
  localparam logic [7:0] PFX_EXT  = 8'hE0;
  localparam logic [7:0] PFX_BRK  = 8'hF0;

  logic [SYNC_STAGES-1:0] ck_sr, dt_sr;
  logic                   ck_s, dt_s, ck_d, fall;
  logic [IW-1:0]          idle_cnt;
  logic                   idle_full;
  logic [3:0]             bit_n, cur_n;
  logic [10:0]            frm, nf;
  logic                   last, good;
  logic                   byte_v;
  logic [7:0]             byte_q;
  logic                   ext, brk;
  logic [31:0]            held;
  logic [4:0]             code;

  assign ck_s      = ck_sr[SYNC_STAGES-1];
  assign dt_s      = dt_sr[SYNC_STAGES-1];
  assign fall      = ck_d & ~ck_s;
  assign idle_full = (idle_cnt == IW'(IDLE_CYCLES));
  assign cur_n     = idle_full ? 4'd0 : bit_n;
  assign nf        = {dt_s, frm[10:1]};
  assign last      = fall && (cur_n == LAST_BIT);
  assign good      = ~nf[0] & nf[10] & (^nf[9:1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_sr <= '1;
      dt_sr <= '1;
    end else begin
      ck_sr <= {ck_sr[SYNC_STAGES-2:0], kb_clk};
      dt_sr <= {dt_sr[SYNC_STAGES-2:0], kb_dat};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_d     <= 1'b1;
      idle_cnt <= '0;
      bit_n    <= '0;
      frm      <= '0;
      byte_v   <= 1'b0;
      byte_q   <= '0;
    end else begin
      ck_d   <= ck_s;
      byte_v <= last & good;
      if (last) byte_q <= nf[8:1];
      if (!ck_s) idle_cnt <= '0;
      else if (!idle_full) idle_cnt <= idle_cnt + 1'b1;
      if (fall) begin
        frm   <= nf;
        bit_n <= last ? 4'd0 : cur_n + 4'd1;
      end else if (idle_full) begin
        bit_n <= '0;
      end
    end
  end

  function automatic logic [4:0] lookup(input logic e, input logic [7:0] sc);
    case ({e, sc})
      {1'b0, 8'h70}: return 5'h00;
      {1'b0, 8'h69}: return 5'h01;
      {1'b0, 8'h72}: return 5'h02;
      {1'b0, 8'h7A}: return 5'h03;
      {1'b0, 8'h6B}: return 5'h04;
      {1'b0, 8'h73}: return 5'h05;
      {1'b0, 8'h74}: return 5'h06;
      {1'b0, 8'h6C}: return 5'h07;
      {1'b0, 8'h75}: return 5'h08;
      {1'b0, 8'h7D}: return 5'h09;
      {1'b0, 8'h5A}: return 5'h0A;
      {1'b1, 8'h5A}: return 5'h0A;
      {1'b1, 8'h71}: return 5'h0B;
      {1'b0, 8'h79}: return 5'h0C;
      {1'b0, 8'h7C}: return 5'h0D;
      {1'b0, 8'h71}: return 5'h0E;
      {1'b0, 8'h77}: return 5'h1A;
      {1'b1, 8'h70}: return 5'h1B;
      {1'b0, 8'h7B}: return 5'h1C;
      {1'b1, 8'h4A}: return 5'h1D;
      default:       return K_NONE;
    endcase
  endfunction

  assign code = lookup(ext, byte_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      key_id <= K_NONE;
      ext    <= 1'b0;
      brk    <= 1'b0;
      held   <= '0;
    end else begin
      key_id <= K_NONE;
      if (byte_v) begin
        if (byte_q == PFX_EXT) begin
          ext <= 1'b1;
        end else if (byte_q == PFX_BRK) begin
          brk <= 1'b1;
        end else begin
          ext <= 1'b0;
          brk <= 1'b0;
          if (code != K_NONE) begin
            if (brk) begin
              held[code] <= 1'b0;
            end else if (!held[code]) begin
              held[code] <= 1'b1;
              key_id     <= code;
            end
          end
        end
      end
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    $past(rst) |-> key_id == K_NONE);

  assert_key_needs_frame_R2: assert property (@(posedge clk) disable iff (rst)
    key_id != K_NONE |-> $past(byte_v));

  assert_held_on_emit_R7: assert property (@(posedge clk) disable iff (rst)
    key_id != K_NONE |-> held[key_id]);

  assert_code_alphabet_R8: assert property (@(posedge clk) disable iff (rst)
    (key_id <= 5'h0E) || (key_id >= 5'h1A && key_id <= 5'h1E));

  assert_single_cycle_R9: assert property (@(posedge clk) disable iff (rst)
    key_id != K_NONE |=> key_id == K_NONE);

  assert_idle_realign_R10: assert property (@(posedge clk) disable iff (rst)
    (idle_full && ck_s) |=> bit_n == 4'd0);

endmodule

// File: tb/kp_keycode_rx_test.sv
module kp_keycode_rx_test;
  localparam int CLK_PERIOD = 10;
  localparam int IDLE       = 40;
  localparam int HALF       = 6;
  localparam int GAP        = 12;
  localparam logic [4:0] NOK = 5'h1E;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic kclk = 1'b1;
  logic kdat = 1'b1;
  logic [4:0] key_id;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit mon_on = 1'b0;
  string phase = "R1";
  logic [4:0] expq[$];
  bit m_held[32];
  bit m_ext = 1'b0;
  bit m_brk = 1'b0;
  logic [4:0] prev = NOK;

  kp_keycode_rx #(.IDLE_CYCLES(IDLE), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .kb_clk(kclk), .kb_dat(kdat), .key_id(key_id));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [4:0] ref_map(input bit e, input logic [7:0] b);
    logic [4:0] r;
    r = NOK;
    if (!e) begin
      case (b)
        8'h70: r = 5'h00; 8'h69: r = 5'h01; 8'h72: r = 5'h02; 8'h7A: r = 5'h03;
        8'h6B: r = 5'h04; 8'h73: r = 5'h05; 8'h74: r = 5'h06; 8'h6C: r = 5'h07;
        8'h75: r = 5'h08; 8'h7D: r = 5'h09; 8'h79: r = 5'h0C; 8'h7B: r = 5'h1C;
        8'h7C: r = 5'h0D; 8'h71: r = 5'h0E; 8'h77: r = 5'h1A; 8'h5A: r = 5'h0A;
        default: r = NOK;
      endcase
    end else begin
      case (b)
        8'h5A: r = 5'h0A; 8'h4A: r = 5'h1D; 8'h71: r = 5'h0B; 8'h70: r = 5'h1B;
        default: r = NOK;
      endcase
    end
    return r;
  endfunction

  task automatic model(input logic [7:0] b);
    logic [4:0] id;
    if (b == 8'hE0) m_ext = 1'b1;
    else if (b == 8'hF0) m_brk = 1'b1;
    else begin
      id = ref_map(m_ext, b);
      if (id != NOK) begin
        if (m_brk) m_held[id] = 1'b0;
        else if (!m_held[id]) begin
          m_held[id] = 1'b1;
          expq.push_back(id);
        end
      end
      m_ext = 1'b0;
      m_brk = 1'b0;
    end
  endtask

  task automatic send_frame(input logic [7:0] b, input int mode);
    logic [10:0] f;
    f = {1'b1, ~^b, b, 1'b0};
    if (mode == 1) f[9] = ~f[9];
    if (mode == 2) f[10] = 1'b0;
    if (mode == 3) f[0] = 1'b1;
    for (int i = 0; i < 11; i++) begin
      kdat = f[i];
      repeat (HALF) @(negedge clk);
      kclk = 1'b0;
      repeat (HALF) @(negedge clk);
      kclk = 1'b1;
    end
    kdat = 1'b1;
    repeat (GAP) @(negedge clk);
  endtask

  task automatic tx(input logic [7:0] b);
    model(b);
    send_frame(b, 0);
  endtask

  task automatic tap(input logic [7:0] b);
    tx(b); tx(8'hF0); tx(b);
  endtask

  task automatic tap_ext(input logic [7:0] b);
    tx(8'hE0); tx(b); tx(8'hE0); tx(8'hF0); tx(b);
  endtask

  task automatic settle(input string tag);
    repeat (20) @(negedge clk);
    checks++;
    if (expq.size() != 0) begin
      errors++;
      $display("FAIL %s missing keys: actual pending %0d expected 0", tag, expq.size());
      expq.delete();
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (prev != NOK && key_id != NOK) begin
        checks++; errors++;
        $display("FAIL R9 key held two cycles: actual %h expected %h", key_id, NOK);
      end
      if (key_id != NOK) begin
        checks++;
        if (expq.size() == 0) begin
          errors++;
          $display("FAIL %s unexpected key: actual %h expected %h", phase, key_id, NOK);
        end else begin
          logic [4:0] e;
          e = expq.pop_front();
          if (key_id != e) begin
            errors++;
            $display("FAIL %s key: actual %h expected %h", phase, key_id, e);
          end
        end
      end
      prev = key_id;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (key_id !== NOK) begin
      errors++;
      $display("FAIL R1 during reset: actual %h expected %h", key_id, NOK);
    end
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    checks++;
    if (key_id !== NOK) begin
      errors++;
      $display("FAIL R1 after reset: actual %h expected %h", key_id, NOK);
    end
    mon_on = 1'b1;

    phase = "R3";
    tap(8'h70); tap(8'h69); tap(8'h72); tap(8'h7A); tap(8'h6B);
    tap(8'h73); tap(8'h74); tap(8'h6C); tap(8'h75); tap(8'h7D);
    settle("R3");

    phase = "R4";
    tap(8'h79); tap(8'h7B); tap(8'h7C); tap(8'h71); tap(8'h77);
    tap(8'h5A); tap_ext(8'h5A); tap_ext(8'h4A);
    settle("R4");

    phase = "R5";
    tap_ext(8'h71); tap(8'h71); tap_ext(8'h70); tap(8'h70);
    settle("R5");

    phase = "R6";
    tx(8'hF0); tx(8'h73); tx(8'hE0); tx(8'hF0); tx(8'h70);
    settle("R6");

    phase = "R7";
    tx(8'h73); tx(8'h73); tx(8'h73); tx(8'h73);
    tx(8'hF0); tx(8'h73); tx(8'h73); tx(8'hF0); tx(8'h73);
    tx(8'hE0); tx(8'h70); tx(8'hE0); tx(8'h70); tx(8'hE0); tx(8'hF0); tx(8'h70);
    settle("R7");

    phase = "R8";
    tap(8'h4A); tap(8'h1C); tap(8'h29); tx(8'hE0); tx(8'h1C); tx(8'h74);
    tx(8'hF0); tx(8'h74);
    settle("R8");

    phase = "R2";
    send_frame(8'h75, 1); send_frame(8'h75, 2); send_frame(8'h75, 3);
    settle("R2");
    tap(8'h75);
    settle("R2");

    phase = "R10";
    for (int i = 0; i < 5; i++) begin
      kdat = i[0];
      repeat (HALF) @(negedge clk);
      kclk = 1'b0;
      repeat (HALF) @(negedge clk);
      kclk = 1'b1;
    end
    kdat = 1'b1;
    repeat (IDLE + 20) @(negedge clk);
    tap(8'h6C);
    tap(8'h7D);
    settle("R10");

    mon_on = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule